// File: doc/BRIEF.md
# Synchronous Serial Master with Timed Transfer Flags

This block drives an 8-bit master-mode synchronous serial link. It has a one-entry transmit holding register, a shift engine and a reload-counter rate generator. The generator ticks every `reload + 1` clock cycles. Each tick is one half of a bit time, and the serial clock toggles on ticks while a character is in flight. Clock polarity and clock phase inputs choose the idle level of the serial clock. They also choose which edge latches data and which edge shifts it. Data leaves MSB first on the output line and is sampled from the input line on the latching edges.

Three flags report progress. Their set and clear points are tied to the rate generator and to the serial clock edges, not to the moment a byte completes:
- **busy** covers the time the shift engine holds a character.
- **transmit request** means the holding register may be refilled.
- **receive request** means a received byte is ready.

The two request flags and a write-error flag are sticky. Each is cleared by its own clear strobe. A byte written while the holding register still has a waiting byte moves into the shifter when the current character ends, so consecutive characters follow with no added bit time.

Top module: `sser_master`

## Requirements
- R1: After reset, busy, transmit request, receive request and write error are 0, the serial clock is 0 and the received-byte output is 0.
- R2: Within a character, successive serial clock edges are exactly `reload + 1` cycles apart, and every character produces exactly 16 serial clock edges.
- R3: After an accepted write to an idle, enabled block, busy rises on the next rate tick. Counting from the write cycle, busy is seen between 2 and `reload + 2` cycles later.
- R4: When no further byte is waiting, busy falls exactly one half bit (`reload + 1` cycles) after the last latching edge of the final character.
- R5: A write accepted while enabled and not busy raises the transmit request in the very next cycle, at any reload value.
- R6: A write accepted while busy does not raise the transmit request at once. The request rises in the same cycle as the last latching edge of the character in flight, and no request rises at a last latching edge while the holding register is empty.
- R7: If a byte enters the shifter without its request having been raised (for example, it was written while disabled), the transmit request rises in the cycle busy rises.
- R8: The receive request rises in the same cycle as each character's last latching edge. At that point the received-byte output holds the eight sampled bits, first bit in bit 7.
- R9: With polarity P and phase H, the serial clock idles at P. The latching edge is rising when P equals H and falling otherwise. The output line carries the byte MSB first, stable at each latching edge.
- R10: A byte waiting in the holding register starts with busy kept high. The first edge of the next character follows the last edge of the previous one by one half bit when H = 0, and by two half bits when H = 1.
- R11: A write while the holding register is full is ignored (that byte is never sent) and sets the write error. Each sticky flag clears on its own clear strobe.
- R12: With enable low the rate generator does not tick, so no transfer starts and busy stays low even with a byte waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enables the rate generator |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase: 0 latches on the first edge, 1 on the second |
| reload | input | RLW | Rate reload; half bit = reload + 1 cycles |
| wr_en | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | 8 | Byte to transmit |
| clr_tx_req | input | 1 | Clears the transmit request |
| clr_rx_req | input | 1 | Clears the receive request |
| clr_err | input | 1 | Clears the write error |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| busy | output | 1 | Character in flight |
| tx_req | output | 1 | Sticky transmit-holding-empty request |
| rx_req | output | 1 | Sticky receive-complete request |
| wr_err | output | 1 | Sticky write-while-full error |
| rx_data | output | 8 | Last received byte |

## Verification
The hardest state to reach is a second byte arriving while the shifter is busy, followed by a third write while that second byte still waits. Only this sequence shows the request moving to the last latching edge, the continuous hand-over between characters, and the rejected write. The stimulus watches busy at the ports and writes the second byte on the first cycle busy is seen high, then writes again on the next cycle. It does this for every polarity and phase and for several reload values, with the serial output looped back to the input. The disabled-write case reaches the late request by writing with enable low and enabling afterwards.

// File: rtl/sser_pkg.sv
package sser_pkg;

    localparam int CHAR_W = 8;
    localparam int SLOT_W = $clog2(2 * CHAR_W + 2);

    typedef logic [CHAR_W-1:0] char_t;

    typedef struct packed {
        logic              busy;
        logic [SLOT_W-1:0] slot;
        char_t             tx;
        char_t             rx;
        logic              sclk;
        logic              mosi;
    } shf_state_t;

    typedef struct packed {
        char_t hold;
        logic  full;
        logic  ann;
        logic  txr;
        logic  rxr;
        logic  err;
        char_t rxd;
    } ctl_state_t;

endpackage

// File: rtl/sser_baud.sv
module sser_baud #(
    parameter int RLW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic [RLW-1:0] reload,
    output logic           tick
);

    typedef struct packed {
        logic [RLW-1:0] cnt;
    } baud_state_t;

    baud_state_t q, d;

    always_comb begin
        d    = q;
        tick = 1'b0;
        if (!en) begin
            d.cnt = reload;
        end else if (q.cnt == '0) begin
            tick  = 1'b1;
            d.cnt = reload;
        end else begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R12: a disabled generator leaves its count parked at the reload value
    a_r12_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (q.cnt == $past(reload)));

endmodule

// File: rtl/sser_shifter.sv
module sser_shifter
    import sser_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  logic  cpol,
    input  logic  cpha,
    input  logic  have_data,
    input  char_t data,
    input  logic  miso,
    output logic  sclk,
    output logic  mosi,
    output logic  busy,
    output logic  take,
    output logic  last_latch,
    output char_t rx_byte
);

    localparam logic [SLOT_W-1:0] K_EDGES = SLOT_W'(2 * CHAR_W);
    localparam logic [SLOT_W-1:0] K_TAIL  = SLOT_W'(2 * CHAR_W + 1);
    localparam logic [SLOT_W-1:0] K_LAST0 = SLOT_W'(2 * CHAR_W - 1);

    shf_state_t        q, d;
    logic [SLOT_W-1:0] k;
    logic              latch_ev;
    logic              present_ev;
    logic              at_end;

    always_comb begin
        d          = q;
        take       = 1'b0;
        last_latch = 1'b0;
        rx_byte    = {q.rx[CHAR_W-2:0], miso};
        k          = q.slot + 1'b1;
        latch_ev   = (k <= K_EDGES) && (k[0] != cpha);
        present_ev = (k <  K_EDGES) && (k[0] == cpha);
        at_end     = (k == (cpha ? K_TAIL : K_EDGES));

        if (!q.busy) begin
            d.sclk = cpol;
        end else if (tick) begin
            d.slot = k;
            if (k <= K_EDGES) begin
                d.sclk = ~q.sclk;
            end
            if (latch_ev) begin
                d.rx = rx_byte;
                if (k == (cpha ? K_EDGES : K_LAST0)) begin
                    last_latch = 1'b1;
                end
            end
            if (present_ev) begin
                d.mosi = q.tx[CHAR_W-1];
                d.tx   = {q.tx[CHAR_W-2:0], 1'b0};
            end
            if (at_end && !have_data) begin
                d.busy = 1'b0;
                d.slot = '0;
            end
        end

        if (tick && have_data && (!q.busy || at_end)) begin
            take   = 1'b1;
            d.busy = 1'b1;
            d.slot = '0;
            if (!cpha) begin
                d.mosi = data[CHAR_W-1];
                d.tx   = {data[CHAR_W-2:0], 1'b0};
            end else begin
                d.tx = data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sclk = q.sclk;
    assign mosi = q.mosi;
    assign busy = q.busy;

    // R9: output data never moves on a tick that latches
    a_r9_mosi_steady_on_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && tick && latch_ev) |=> $stable(mosi));

    // R2: a character never runs past its final slot
    a_r2_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.slot <= K_TAIL));

endmodule

// File: rtl/sser_master.sv
module sser_master
    import sser_pkg::*;
#(
    parameter int RLW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [RLW-1:0]    reload,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              clr_tx_req,
    input  logic              clr_rx_req,
    input  logic              clr_err,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              tx_req,
    output logic              rx_req,
    output logic              wr_err,
    output logic [CHAR_W-1:0] rx_data
);

    ctl_state_t q, d;
    logic       tick;
    logic       take;
    logic       last_latch;
    char_t      rx_byte;
    logic       accept;
    logic       reject;
    logic       tx_set;

    sser_baud #(.RLW(RLW)) baud_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .reload (reload),
        .tick   (tick)
    );

    sser_shifter shf_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .cpol       (cpol),
        .cpha       (cpha),
        .have_data  (q.full),
        .data       (q.hold),
        .miso       (miso),
        .sclk       (sclk),
        .mosi       (mosi),
        .busy       (busy),
        .take       (take),
        .last_latch (last_latch),
        .rx_byte    (rx_byte)
    );

    always_comb begin
        d      = q;
        accept = wr_en && !q.full;
        reject = wr_en && q.full;
        tx_set = 1'b0;

        if (take) begin
            d.full = 1'b0;
            if (!q.ann) begin
                tx_set = 1'b1;
            end
        end
        if (last_latch && q.full && !q.ann) begin
            tx_set = 1'b1;
            d.ann  = 1'b1;
        end
        if (accept) begin
            d.hold = wr_data;
            d.full = 1'b1;
            d.ann  = en && !busy;
            if (en && !busy) begin
                tx_set = 1'b1;
            end
        end

        if (clr_tx_req) d.txr = 1'b0;
        if (tx_set)     d.txr = 1'b1;

        if (clr_rx_req) d.rxr = 1'b0;
        if (last_latch) begin
            d.rxr = 1'b1;
            d.rxd = rx_byte;
        end

        if (clr_err) d.err = 1'b0;
        if (reject)  d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign tx_req  = q.txr;
    assign rx_req  = q.rxr;
    assign wr_err  = q.err;
    assign rx_data = q.rxd;

    // R5: write to an idle enabled block gives an immediate request
    a_r5_req_on_idle_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !q.full && en && !busy) |=> tx_req);

    // R11: write into a full holding register is dropped and flagged
    a_r11_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && q.full) |=> (wr_err && $stable(q.hold)));

    // R8: every last latching edge leaves a receive request behind
    a_r8_rx_req_on_last_latch: assert property (@(posedge clk) disable iff (!rst_n)
        last_latch |=> rx_req);

    // R2: serial clock only moves on a rate tick during a transfer
    a_r2_sclk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(sclk));

    // R10: busy can only end on a tick
    a_r10_busy_ends_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> busy);

    // R12: nothing starts while disabled
    a_r12_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !busy) |=> !busy);

endmodule

// File: tb/sser_master_tb.sv
module sser_master_tb_top;

    localparam int RLW = 8;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           en;
    logic           cpol;
    logic           cpha;
    logic [RLW-1:0] reload;
    logic           wr_en;
    logic [7:0]     wr_data;
    logic           clr_tx_req;
    logic           clr_rx_req;
    logic           clr_err;
    logic           line;
    logic           sclk;
    logic           busy;
    logic           tx_req;
    logic           rx_req;
    logic           wr_err;
    logic [7:0]     rx_data;

    int cyc      = 0;
    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sser_master #(.RLW(RLW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .cpol       (cpol),
        .cpha       (cpha),
        .reload     (reload),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .clr_tx_req (clr_tx_req),
        .clr_rx_req (clr_rx_req),
        .clr_err    (clr_err),
        .miso       (line),
        .sclk       (sclk),
        .mosi       (line),
        .busy       (busy),
        .tx_req     (tx_req),
        .rx_req     (rx_req),
        .wr_err     (wr_err),
        .rx_data    (rx_data)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input string what, input int act,
                             input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic idle_drive();
        wr_en      = 1'b0;
        clr_tx_req = 1'b0;
        clr_rx_req = 1'b0;
        clr_err    = 1'b0;
    endtask

    // two characters back to back plus a rejected third write
    task automatic run_pair(input logic pol, input logic pha, input int rl,
                            input logic [7:0] b0, input logic [7:0] b1);
        int       st        = 0;
        int       w0;
        int       edges     = 0;
        int       latches   = 0;
        int       last_edge = 0;
        int       ll_cyc    = 0;
        int       fall_cyc  = 0;
        logic     prev_sclk;
        logic     prev_busy;
        logic     prev_tx;
        logic     prev_rx;
        logic [7:0] cap     = 8'h00;
        logic [7:0] expb;
        @(negedge clk);
        en = 1'b0; cpol = pol; cpha = pha; reload = RLW'(rl);
        @(negedge clk);
        en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9", "idle sclk level", int'(sclk), int'(pol));
        wr_en = 1'b1; wr_data = b0; w0 = cyc;
        prev_sclk = sclk; prev_busy = busy; prev_tx = tx_req; prev_rx = rx_req;
        forever begin
            @(negedge clk);
            idle_drive();
            case (st)
                0: begin
                    chk("R5", "tx_req right after idle write", int'(tx_req), 1);
                    chk("R3", "busy not yet set after write", int'(busy), 0);
                    clr_tx_req = 1'b1;
                    st = 1;
                end
                1: if (busy) begin
                    chk_range("R3", "busy delay after write", cyc - w0, 2, rl + 2);
                    wr_en = 1'b1; wr_data = b1;
                    st = 2;
                end
                2: begin
                    chk("R6", "no tx_req at busy-time write", int'(tx_req), 0);
                    chk("R11", "no error on first write", int'(wr_err), 0);
                    wr_en = 1'b1; wr_data = ~b1;
                    st = 3;
                end
                3: begin
                    chk("R11", "error on full write", int'(wr_err), 1);
                    clr_err = 1'b1;
                    st = 4;
                end
                default: ;
            endcase
            if (sclk != prev_sclk) begin
                edges++;
                if (edges == 17) begin
                    chk("R10", "gap between characters", cyc - last_edge,
                        (pha ? 2 : 1) * (rl + 1));
                end else if (edges > 1) begin
                    chk("R2", "edge spacing", cyc - last_edge, rl + 1);
                end
                last_edge = cyc;
                if (sclk == (pol == pha)) begin
                    cap = {cap[6:0], line};
                    latches++;
                    if (latches % 8 == 0) begin
                        expb = (latches == 8) ? b0 : b1;
                        chk("R9", "serialized byte", int'(cap), int'(expb));
                        chk("R8", "rx_req rises at last latch", int'({prev_rx, rx_req}), 1);
                        chk("R8", "received byte", int'(rx_data), int'(expb));
                        clr_rx_req = 1'b1;
                        ll_cyc = cyc;
                        if (latches == 8) begin
                            chk("R6", "tx_req rises at last latch", int'({prev_tx, tx_req}), 1);
                            clr_tx_req = 1'b1;
                        end else begin
                            chk("R6", "no tx_req with empty holding", int'(tx_req), 0);
                        end
                    end
                end
            end
            if (!busy && prev_busy) begin
                fall_cyc = cyc;
                break;
            end
            prev_sclk = sclk; prev_busy = busy; prev_tx = tx_req; prev_rx = rx_req;
        end
        chk("R4", "busy fall after last latch", fall_cyc - ll_cyc, rl + 1);
        chk("R2", "edges for two characters", edges, 32);
        chk("R10", "two characters without busy drop", latches, 16);
        chk("R9", "sclk back at idle", int'(sclk), int'(pol));
        repeat (4 * (rl + 1) + 4) @(negedge clk);
        chk("R11", "rejected byte never sent", int'(busy), 0);
        chk("R11", "tx_req stays low", int'(tx_req), 0);
        clr_rx_req = 1'b1; clr_tx_req = 1'b1;
        @(negedge clk);
        idle_drive();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; en = 1'b0; cpol = 1'b0; cpha = 1'b0; reload = '0;
        wr_data = 8'h00;
        idle_drive();
        repeat (3) @(negedge clk);
        chk("R1", "busy after reset", int'(busy), 0);
        chk("R1", "tx_req after reset", int'(tx_req), 0);
        chk("R1", "rx_req after reset", int'(rx_req), 0);
        chk("R1", "wr_err after reset", int'(wr_err), 0);
        chk("R1", "sclk after reset", int'(sclk), 0);
        chk("R1", "rx_data after reset", int'(rx_data), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // disabled write, then enable: late request (R7, R12)
        reload = RLW'(1);
        wr_en = 1'b1; wr_data = 8'h3C;
        @(negedge clk);
        idle_drive();
        repeat (10) @(negedge clk);
        chk("R12", "no start while disabled", int'(busy), 0);
        chk("R7", "no request while disabled", int'(tx_req), 0);
        en = 1'b1;
        while (!busy) @(negedge clk);
        chk("R7", "tx_req with busy rise", int'(tx_req), 1);
        while (busy) @(negedge clk);
        chk("R8", "byte from disabled write", int'(rx_data), 8'h3C);
        clr_tx_req = 1'b1; clr_rx_req = 1'b1;
        @(negedge clk);
        idle_drive();
        @(negedge clk);
        chk("R11", "clear strobes drop tx_req", int'(tx_req), 0);
        chk("R11", "clear strobes drop rx_req", int'(rx_req), 0);

        for (int m = 0; m < 4; m++) begin
            for (int r = 0; r < 3; r++) begin
                int rl = (r == 2) ? 3 : r;
                int idx = m * 3 + r;
                run_pair(m[1], m[0], rl, 8'(idx * 53 + 8'h5A), 8'(idx * 29) ^ 8'hC3);
            end
        end
        run_pair(1'b0, 1'b1, 2, 8'h00, 8'hFF);
        run_pair(1'b1, 1'b0, 0, 8'h80, 8'h01);
        finish_run();
    end

endmodule